// File: doc/BRIEF.md
# Capability Revocation Sweep Engine

This block walks a programmed window of capability memory and invalidates every stored capability whose referenced region has been marked as freed. The window is stepped one 8-byte capability slot at a time. For each slot that holds a valid (tagged) capability, the engine takes the capability's base address and finds its bit in a revocation bitmap, where each bit stands for one 8-byte granule. If that bit is set, the slot is written back with the same data and a cleared tag. What decides the outcome is the base address the capability points to, not the address where the capability is stored.

Software drives the engine through six 32-bit registers. It sets the window, starts a sweep, and then either polls an epoch counter, whose low bit shows the sweep in progress, or waits for a completion interrupt. The engine has two memory request ports, one to the capability store and one to the bitmap. Both use request/grant with a read response one cycle after the grant. The model takes the capability's base from a fixed field of the stored data.

Top module: `cap_revoker`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Registers sit at byte offsets 0 (sweep first slot), 4 (sweep last slot, inclusive), 8 (go), 12 (epoch), 16 (done status, bit 0) and 20 (interrupt enable, bit 0). Offset 8 reads 0. The low 3 bits of offsets 0 and 4 always read 0, whatever was written.
- R3: Writing bit 0 = 1 to offset 8 while idle starts a sweep, and epoch bit 0 reads 1 from the next cycle on.
- R4: A sweep reads every 8-byte slot from the first address to the last, inclusive. For a tagged slot, the base is bits [31:0] of the 64-bit data. The engine reads bitmap word base[31:8] and tests bit base[7:3]. If that bit is 1, it writes the same data back with the tag cleared.
- R5: Whether a slot is cleared depends only on the granule of the base, not on where the slot is stored. A capability stored in a revoked granule with an unrevoked base keeps its tag.
- R6: An untagged slot causes no bitmap read and no write. A tagged slot with an unrevoked base causes no write.
- R7: The epoch rises by exactly 1 at the start of a sweep and by 1 at its end. The end also sets the done status. Writing bit 0 = 0 to offset 16 clears the status, and writing bit 0 = 1 there has no effect.
- R8: `irq_o` is high exactly when the done status and the interrupt enable (offset 20, bit 0) are both 1.
- R9: A go write during a running sweep is ignored. The epoch does not move, and the sweep ends with the epoch exactly 2 above its idle value.
- R10: Writes to offsets 0 and 4 while a sweep runs are ignored, and the running sweep keeps its original window.
- R11: If the first address is above the last one, the sweep completes with no memory access. The epoch still advances by 2 and the status is set.
- R12: When a sweep completes in the same cycle as a status-clear write, the status ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Completion interrupt |
| cap_req_o | output | 1 | Capability memory request |
| cap_we_o | output | 1 | Write-back with tag cleared |
| cap_addr_o | output | 32 | Capability slot byte address |
| cap_wdata_o | output | 64 | Write-back data |
| cap_gnt_i | input | 1 | Capability request granted |
| cap_rvalid_i | input | 1 | Capability read response valid |
| cap_rdata_i | input | 64 | Capability read data |
| cap_rtag_i | input | 1 | Tag of the read slot |
| bm_req_o | output | 1 | Bitmap read request |
| bm_addr_o | output | 24 | Bitmap word index |
| bm_gnt_i | input | 1 | Bitmap request granted |
| bm_rvalid_i | input | 1 | Bitmap read response valid |
| bm_rdata_i | input | 32 | Bitmap word |

## Verification
Sweep completion setting the done status and a software write clearing it can land on the same clock edge. With grant stalls turned off, the bench starts a one-slot sweep on an untagged slot. It watches the capability port for the grant on that slot and counts the fixed cycles to the closing cycle, then puts the clear write on exactly that edge. The collision passes if the status reads back 1 and the interrupt stays high. A design that lets the clear win leaves the status at 0.

// File: rtl/cap_revoker_pkg.sv
package cap_revoker_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned REG_AW = 5;

  localparam logic [2:0] IDX_FIRST = 3'd0;
  localparam logic [2:0] IDX_LAST  = 3'd1;
  localparam logic [2:0] IDX_GO    = 3'd2;
  localparam logic [2:0] IDX_EPOCH = 3'd3;
  localparam logic [2:0] IDX_DONE  = 3'd4;
  localparam logic [2:0] IDX_IEN   = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAP_RD,
    ST_CAP_WAIT,
    ST_BM_RD,
    ST_BM_WAIT,
    ST_CAP_WR,
    ST_FINISH
  } sweep_st_e;
endpackage

// File: rtl/cap_revoker_regs.sv
module cap_revoker_regs
  import cap_revoker_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned GRAN_LG = 3,
  parameter int unsigned EPOCH_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               done_i,
  output logic               go_o,
  output logic [ADDR_W-1:0]  first_o,
  output logic [ADDR_W-1:0]  last_o,
  output logic [EPOCH_W-1:0] epoch_o,
  output logic               status_o,
  output logic               ien_o,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << GRAN_LG) - 64'd1);

  logic [ADDR_W-1:0]  first_q, last_q;
  logic [EPOCH_W-1:0] epoch_q;
  logic               status_q, ien_q;
  logic               aligned, wr, running;
  logic [2:0]         idx;

  assign aligned = (reg_addr_i[1:0] == 2'b00);
  assign idx     = reg_addr_i[4:2];
  assign wr      = reg_req_i && reg_we_i && aligned;
  assign running = epoch_q[0];
  assign go_o    = wr && (idx == IDX_GO) && reg_wdata_i[0] && !running;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= '0;
      last_q   <= '0;
      epoch_q  <= '0;
      status_q <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      // window is frozen while a sweep runs
      if (wr && !running && idx == IDX_FIRST) first_q <= reg_wdata_i[ADDR_W-1:0] & ~LOW_MASK;
      if (wr && !running && idx == IDX_LAST)  last_q  <= reg_wdata_i[ADDR_W-1:0] & ~LOW_MASK;
      if (go_o || done_i) epoch_q <= epoch_q + EPOCH_W'(1);
      // completion beats a same-cycle clear
      if (done_i) status_q <= 1'b1;
      else if (wr && idx == IDX_DONE && !reg_wdata_i[0]) status_q <= 1'b0;
      if (wr && idx == IDX_IEN) ien_q <= reg_wdata_i[0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      unique case (idx)
        IDX_FIRST: reg_rdata_o = REG_W'(first_q);
        IDX_LAST:  reg_rdata_o = REG_W'(last_q);
        IDX_EPOCH: reg_rdata_o = REG_W'(epoch_q);
        IDX_DONE:  reg_rdata_o = REG_W'(status_q);
        IDX_IEN:   reg_rdata_o = REG_W'(ien_q);
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  assign first_o  = first_q;
  assign last_o   = last_q;
  assign epoch_o  = epoch_q;
  assign status_o = status_q;
  assign ien_o    = ien_q;
  assign irq_o    = status_q & ien_q;
endmodule

// File: rtl/cap_revoker_bitsel.sv
module cap_revoker_bitsel #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_LG   = 3,
  parameter int unsigned BM_WORD_W = 32,
  localparam int unsigned BIT_LG   = $clog2(BM_WORD_W),
  localparam int unsigned GIDX_W   = ADDR_W - GRAN_LG,
  localparam int unsigned BM_AW    = GIDX_W - BIT_LG
) (
  input  logic [GIDX_W-1:0]    gidx_i,
  input  logic [BM_WORD_W-1:0] bm_word_i,
  output logic [BM_AW-1:0]     bm_addr_o,
  output logic                 revoked_o
);
  logic [BIT_LG-1:0] bit_idx;

  assign bm_addr_o = gidx_i[GIDX_W-1:BIT_LG];
  assign bit_idx   = gidx_i[BIT_LG-1:0];
  assign revoked_o = bm_word_i[bit_idx];
endmodule

// File: rtl/cap_revoker_sweep.sv
module cap_revoker_sweep
  import cap_revoker_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CAP_W     = 64,
  parameter int unsigned BASE_LSB  = 0,
  parameter int unsigned GRAN_LG   = 3,
  parameter int unsigned BM_WORD_W = 32,
  localparam int unsigned GIDX_W   = ADDR_W - GRAN_LG,
  localparam int unsigned BM_AW    = GIDX_W - $clog2(BM_WORD_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic [ADDR_W-1:0]    first_i,
  input  logic [ADDR_W-1:0]    last_i,
  output logic                 done_o,
  output logic                 cap_req_o,
  output logic                 cap_we_o,
  output logic [ADDR_W-1:0]    cap_addr_o,
  output logic [CAP_W-1:0]     cap_wdata_o,
  input  logic                 cap_gnt_i,
  input  logic                 cap_rvalid_i,
  input  logic [CAP_W-1:0]     cap_rdata_i,
  input  logic                 cap_rtag_i,
  output logic                 bm_req_o,
  output logic [BM_AW-1:0]     bm_addr_o,
  input  logic                 bm_gnt_i,
  input  logic                 bm_rvalid_i,
  input  logic [BM_WORD_W-1:0] bm_rdata_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(64'd1 << GRAN_LG);

  sweep_st_e         state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [CAP_W-1:0]  cap_q;
  logic              cap_ld, adv, at_last, revoked;

  cap_revoker_bitsel #(
    .ADDR_W   (ADDR_W),
    .GRAN_LG  (GRAN_LG),
    .BM_WORD_W(BM_WORD_W)
  ) u_bitsel (
    .gidx_i   (cap_q[BASE_LSB+GRAN_LG +: GIDX_W]),
    .bm_word_i(bm_rdata_i),
    .bm_addr_o(bm_addr_o),
    .revoked_o(revoked)
  );

  assign at_last = (cur_q == last_i);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    cap_ld  = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go_i) begin
        cur_d   = first_i;
        state_d = (first_i > last_i) ? ST_FINISH : ST_CAP_RD;
      end
      ST_CAP_RD: if (cap_gnt_i) state_d = ST_CAP_WAIT;
      ST_CAP_WAIT: if (cap_rvalid_i) begin
        cap_ld = 1'b1;
        if (cap_rtag_i) state_d = ST_BM_RD;
        else adv = 1'b1;
      end
      ST_BM_RD: if (bm_gnt_i) state_d = ST_BM_WAIT;
      ST_BM_WAIT: if (bm_rvalid_i) begin
        if (revoked) state_d = ST_CAP_WR;
        else adv = 1'b1;
      end
      ST_CAP_WR: if (cap_gnt_i) adv = 1'b1;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    if (adv) begin
      if (at_last) state_d = ST_FINISH;
      else begin
        state_d = ST_CAP_RD;
        cur_d   = cur_q + STEP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      if (cap_ld) cap_q <= cap_rdata_i;
    end
  end

  assign cap_req_o   = (state_q == ST_CAP_RD) || (state_q == ST_CAP_WR);
  assign cap_we_o    = (state_q == ST_CAP_WR);
  assign cap_addr_o  = cur_q;
  assign cap_wdata_o = cap_q;
  assign bm_req_o    = (state_q == ST_BM_RD);
  assign done_o      = (state_q == ST_FINISH);
endmodule

// File: rtl/cap_revoker.sv
module cap_revoker
  import cap_revoker_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CAP_W     = 64,
  parameter int unsigned BASE_LSB  = 0,
  parameter int unsigned GRAN_LG   = 3,
  parameter int unsigned BM_WORD_W = 32,
  parameter int unsigned EPOCH_W   = 32,
  localparam int unsigned BM_AW    = ADDR_W - GRAN_LG - $clog2(BM_WORD_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_o,
  output logic                 cap_req_o,
  output logic                 cap_we_o,
  output logic [ADDR_W-1:0]    cap_addr_o,
  output logic [CAP_W-1:0]     cap_wdata_o,
  input  logic                 cap_gnt_i,
  input  logic                 cap_rvalid_i,
  input  logic [CAP_W-1:0]     cap_rdata_i,
  input  logic                 cap_rtag_i,
  output logic                 bm_req_o,
  output logic [BM_AW-1:0]     bm_addr_o,
  input  logic                 bm_gnt_i,
  input  logic                 bm_rvalid_i,
  input  logic [BM_WORD_W-1:0] bm_rdata_i
);
  logic               go_w, done_w, status_w, ien_w;
  logic [ADDR_W-1:0]  first_w, last_w;
  logic [EPOCH_W-1:0] epoch_w;

  cap_revoker_regs #(
    .ADDR_W (ADDR_W),
    .GRAN_LG(GRAN_LG),
    .EPOCH_W(EPOCH_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_req_i  (reg_req_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .done_i     (done_w),
    .go_o       (go_w),
    .first_o    (first_w),
    .last_o     (last_w),
    .epoch_o    (epoch_w),
    .status_o   (status_w),
    .ien_o      (ien_w),
    .irq_o      (irq_o)
  );

  cap_revoker_sweep #(
    .ADDR_W   (ADDR_W),
    .CAP_W    (CAP_W),
    .BASE_LSB (BASE_LSB),
    .GRAN_LG  (GRAN_LG),
    .BM_WORD_W(BM_WORD_W)
  ) u_sweep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go_w),
    .first_i     (first_w),
    .last_i      (last_w),
    .done_o      (done_w),
    .cap_req_o   (cap_req_o),
    .cap_we_o    (cap_we_o),
    .cap_addr_o  (cap_addr_o),
    .cap_wdata_o (cap_wdata_o),
    .cap_gnt_i   (cap_gnt_i),
    .cap_rvalid_i(cap_rvalid_i),
    .cap_rdata_i (cap_rdata_i),
    .cap_rtag_i  (cap_rtag_i),
    .bm_req_o    (bm_req_o),
    .bm_addr_o   (bm_addr_o),
    .bm_gnt_i    (bm_gnt_i),
    .bm_rvalid_i (bm_rvalid_i),
    .bm_rdata_i  (bm_rdata_i)
  );
endmodule

// File: rtl/cap_revoker_chk.sv
module cap_revoker_chk
  import cap_revoker_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned GRAN_LG = 3,
  parameter int unsigned BM_AW   = 24,
  parameter int unsigned EPOCH_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_req_i,
  input logic               reg_we_i,
  input logic [REG_AW-1:0]  reg_addr_i,
  input logic               wdata0_i,
  input logic               irq_o,
  input logic               cap_req_o,
  input logic               cap_we_o,
  input logic [ADDR_W-1:0]  cap_addr_o,
  input logic               cap_gnt_i,
  input logic               bm_req_o,
  input logic [BM_AW-1:0]   bm_addr_o,
  input logic               bm_gnt_i,
  input logic [EPOCH_W-1:0] epoch_i,
  input logic               done_i,
  input logic               status_i,
  input logic               ien_i
);
  logic go_wr, ien_wr;
  assign go_wr  = reg_req_i && reg_we_i && (reg_addr_i == {IDX_GO, 2'b00}) && wdata0_i;
  assign ien_wr = reg_req_i && reg_we_i && (reg_addr_i == {IDX_IEN, 2'b00});

  p_one_port_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_req_o && bm_req_o));

  p_slot_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_req_o |-> (cap_addr_o[GRAN_LG-1:0] == '0));

  p_cap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_req_o && !cap_gnt_i) |=> (cap_req_o && $stable(cap_addr_o) && $stable(cap_we_o)));

  p_bm_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_req_o && !bm_gnt_i) |=> (bm_req_o && $stable(bm_addr_o)));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_i[0] |-> (!cap_req_o && !bm_req_o));

  p_epoch_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epoch_i != $past(epoch_i)) |-> (epoch_i == $past(epoch_i) + EPOCH_W'(1)));

  p_go_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epoch_i[0] && go_wr && !done_i) |=> $stable(epoch_i));

  p_done_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> status_i);

  p_irq_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ien_i && !ien_wr) |=> irq_o);
endmodule

bind cap_revoker cap_revoker_chk #(
  .ADDR_W (ADDR_W),
  .GRAN_LG(GRAN_LG),
  .BM_AW  (BM_AW),
  .EPOCH_W(EPOCH_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_req_i (reg_req_i),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .wdata0_i  (reg_wdata_i[0]),
  .irq_o     (irq_o),
  .cap_req_o (cap_req_o),
  .cap_we_o  (cap_we_o),
  .cap_addr_o(cap_addr_o),
  .cap_gnt_i (cap_gnt_i),
  .bm_req_o  (bm_req_o),
  .bm_addr_o (bm_addr_o),
  .bm_gnt_i  (bm_gnt_i),
  .epoch_i   (epoch_w),
  .done_i    (done_w),
  .status_i  (status_w),
  .ien_i     (ien_w)
);

// File: tb/tb_cap_revoker.sv
module tb_cap_revoker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        cap_req, cap_we, cap_gnt;
  logic [31:0] cap_addr;
  logic [63:0] cap_wdata;
  logic        cap_rvalid = 1'b0, cap_rtag = 1'b0;
  logic [63:0] cap_rdata = '0;
  logic        bm_req, bm_gnt;
  logic [23:0] bm_addr;
  logic        bm_rvalid = 1'b0;
  logic [31:0] bm_rdata = '0;

  logic [63:0] cmem [16];
  logic        ctag [16];
  logic        otag [16];
  logic [31:0] bmem [32];
  logic [7:0]  lfsr = 8'h5A;
  logic        stall_en = 1'b1;
  int          wr_cnt = 0, rd_cnt = 0, bm_cnt = 0, bad_cnt = 0;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cap_revoker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .cap_req_o(cap_req), .cap_we_o(cap_we), .cap_addr_o(cap_addr),
    .cap_wdata_o(cap_wdata), .cap_gnt_i(cap_gnt), .cap_rvalid_i(cap_rvalid),
    .cap_rdata_i(cap_rdata), .cap_rtag_i(cap_rtag),
    .bm_req_o(bm_req), .bm_addr_o(bm_addr), .bm_gnt_i(bm_gnt),
    .bm_rvalid_i(bm_rvalid), .bm_rdata_i(bm_rdata)
  );

  assign cap_gnt = cap_req && (!stall_en || lfsr[0]);
  assign bm_gnt  = bm_req && (!stall_en || lfsr[2]);

  // memory models: slots at 0x300..0x378, bitmap words 0..31
  always @(posedge clk) begin
    lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cap_rvalid <= 1'b0;
    bm_rvalid  <= 1'b0;
    if (cap_req && cap_gnt) begin
      if (cap_addr[31:7] != 25'h6) bad_cnt <= bad_cnt + 1;
      if (cap_we) begin
        cmem[cap_addr[6:3]] <= cap_wdata;
        ctag[cap_addr[6:3]] <= 1'b0;
        wr_cnt <= wr_cnt + 1;
      end else begin
        cap_rdata  <= cmem[cap_addr[6:3]];
        cap_rtag   <= ctag[cap_addr[6:3]];
        cap_rvalid <= 1'b1;
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (bm_req && bm_gnt) begin
      bm_rdata  <= bmem[bm_addr[4:0]];
      bm_rvalid <= 1'b1;
      bm_cnt <= bm_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    reg_req = 1'b0; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    v = 32'h1;
    for (int k = 0; k < 4000 && v[0]; k++) reg_rd(5'd12, v);
    chk(req, {63'd0, v[0]}, 64'd0);
  endtask

  function automatic logic [31:0] base_of(input int i);
    case (i)
      0: return 32'h0500;
      1: return 32'h05F8;
      2: return 32'h0508;
      3: return 32'h1000;
      4: return 32'h0310;
      5: return 32'h0500;
      6: return 32'h1F40;
      7: return 32'h1F48;
      default: return 32'h1000 + 32'(i) * 32'd8;
    endcase
  endfunction

  function automatic logic rev(input logic [31:0] base);
    return bmem[base[12:8]][base[7:3]];
  endfunction

  task automatic load_mem();
    for (int w = 0; w < 32; w++) bmem[w] = 32'h0;
    bmem[3]  = 32'hFFFF_FFFF;
    bmem[5]  = 32'h8000_0001;
    bmem[31] = 32'h0000_0100;
    for (int i = 0; i < 16; i++) begin
      cmem[i] = {32'hA5A5_0000 | 32'(i), base_of(i)};
      ctag[i] = (i != 5);
      otag[i] = ctag[i];
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int r = 0; r < 6; r++) begin
      reg_rd(5'(r * 4), v);
      chk($sformatf("R1 reg offset %0d after reset", r * 4), 64'(v), 64'd0);
    end
    chk("R1 irq after reset", 64'(irq), 64'd0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    reg_wr(5'd0, 32'h305);
    reg_wr(5'd4, 32'h347);
    reg_rd(5'd0, v); chk("R2 first addr low bits", 64'(v), 64'h300);
    reg_rd(5'd4, v); chk("R2 last addr low bits", 64'(v), 64'h340);
    reg_wr(5'd8, 32'h0);
    reg_rd(5'd8, v); chk("R2 go reads zero", 64'(v), 64'd0);
  endtask

  task automatic t_sweep();
    logic [31:0] v;
    int w0, b0, exp_w, exp_b;
    load_mem();
    w0 = wr_cnt; b0 = bm_cnt; exp_w = 0; exp_b = 0;
    for (int i = 0; i <= 8; i++) begin
      if (otag[i]) begin
        exp_b++;
        if (rev(base_of(i))) exp_w++;
      end
    end
    reg_wr(5'd8, 32'h1);
    reg_rd(5'd12, v); chk("R3 running bit after go", 64'(v), 64'd1);
    wait_idle("R7 sweep ends");
    reg_rd(5'd12, v); chk("R7 epoch after sweep", 64'(v), 64'd2);
    reg_rd(5'd16, v); chk("R7 done status set", 64'(v), 64'd1);
    chk("R8 irq masked when disabled", 64'(irq), 64'd0);
    for (int i = 0; i < 16; i++) begin
      logic e;
      e = (i <= 8) ? (otag[i] & ~rev(base_of(i))) : otag[i];
      chk($sformatf("R4 tag of slot %0d", i), 64'(ctag[i]), 64'(e));
    end
    chk("R5 revoked storage, live base keeps tag", 64'(ctag[3]), 64'd1);
    chk("R4 data kept on write-back", cmem[1], {32'hA5A5_0001, 32'h05F8});
    chk("R6 write-back count", 64'(wr_cnt - w0), 64'(exp_w));
    chk("R6 bitmap reads only for tagged slots", 64'(bm_cnt - b0), 64'(exp_b));
    chk("R4 no access outside window", 64'(bad_cnt), 64'd0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    reg_wr(5'd20, 32'h1);
    chk("R8 irq with status and enable", 64'(irq), 64'd1);
    reg_wr(5'd16, 32'h1);
    reg_rd(5'd16, v); chk("R7 writing 1 keeps status", 64'(v), 64'd1);
    reg_wr(5'd16, 32'h0);
    reg_rd(5'd16, v); chk("R7 status cleared", 64'(v), 64'd0);
    chk("R8 irq drops with status", 64'(irq), 64'd0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    int r0;
    load_mem();
    reg_wr(5'd0, 32'h300);
    reg_wr(5'd4, 32'h378);
    r0 = rd_cnt;
    reg_wr(5'd8, 32'h1);
    reg_wr(5'd8, 32'h1);
    reg_wr(5'd0, 32'h0);
    reg_wr(5'd4, 32'h0);
    reg_rd(5'd12, v); chk("R9 epoch unchanged by busy go", 64'(v), 64'd3);
    reg_rd(5'd0, v);  chk("R10 first addr frozen", 64'(v), 64'h300);
    reg_rd(5'd4, v);  chk("R10 last addr frozen", 64'(v), 64'h378);
    wait_idle("R9 busy sweep ends");
    reg_rd(5'd12, v); chk("R9 epoch after busy sweep", 64'(v), 64'd4);
    chk("R10 full window read", 64'(rd_cnt - r0), 64'd16);
    chk("R8 irq on completion", 64'(irq), 64'd1);
    reg_wr(5'd16, 32'h0);
  endtask

  task automatic t_empty();
    logic [31:0] v;
    int a0;
    reg_wr(5'd0, 32'h340);
    reg_wr(5'd4, 32'h300);
    a0 = rd_cnt + wr_cnt + bm_cnt;
    reg_wr(5'd8, 32'h1);
    wait_idle("R11 empty sweep ends");
    reg_rd(5'd12, v); chk("R11 epoch after empty sweep", 64'(v), 64'd6);
    reg_rd(5'd16, v); chk("R11 status after empty sweep", 64'(v), 64'd1);
    chk("R11 no memory access", 64'(rd_cnt + wr_cnt + bm_cnt - a0), 64'd0);
    reg_wr(5'd16, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    stall_en = 1'b0;
    load_mem();
    ctag[0] = 1'b0;
    reg_wr(5'd0, 32'h300);
    reg_wr(5'd4, 32'h300);
    reg_wr(5'd8, 32'h1);
    while (!(cap_req && cap_gnt)) @(negedge clk);
    @(negedge clk);          // read response cycle
    @(negedge clk);          // closing cycle
    reg_wr(5'd16, 32'h0);    // clear lands on the completion edge
    reg_rd(5'd16, v); chk("R12 completion beats clear", 64'(v), 64'd1);
    chk("R12 irq stays high", 64'(irq), 64'd1);
    reg_rd(5'd12, v); chk("R7 epoch after one-slot sweep", 64'(v), 64'd8);
    stall_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_sweep();
    t_irq();
    t_busy();
    t_empty();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule